// File: doc/BRIEF.md
# Level-Sensitive Interrupt Aggregator

This block gathers a parameterised set of level-sensitive interrupt lines (64 unless configured otherwise) into one interrupt request for a processor. Each line has an enable bit. On every clock the block samples the lines and keeps a registered count of lines that are both high and enabled. The processor request stays high while that count is nonzero.

Software reaches the block over a plain 32-bit register port with a byte address, a write strobe, write data and combinational read data. Only the low 12 address bits take part in decoding, so the window repeats every 4 KB. Registers sit at word offsets. Offset 0 is a fixed identification constant. Offset 1 is the pending count. Offset 2 is the lowest-numbered line that is active and enabled. Offset 3 disables every line. Offset 4 disables one line, and offset 5 enables one line; both take the line number as write data. A handler reads offset 2 to find which source to serve. It disables or enables single lines by number, and uses offset 3 to silence everything at once.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: After reset every enable is clear, the pending count reads 0, the request output is low and the current-line register reads 0xFFFFFFFF.
- R2: A read of word offset 0 returns the parameter ID_WORD.
- R3: A read of word offset 1 returns the number of lines whose sample from the latest clock edge is high and whose enable is set.
- R4: A read of word offset 2 returns the lowest line number that is both sampled high and enabled, or 0xFFFFFFFF when no line qualifies.
- R5: A write of any value to word offset 3 clears every enable, and from the next cycle the pending count reads 0.
- R6: A write of value k to word offset 5 sets the enable of line k. If line k is high, the pending count rises by one, or stays the same when k was already enabled.
- R7: A write of value k to word offset 4 clears the enable of line k. The pending count falls by one only if line k was enabled and is high.
- R8: Enable and disable writes whose full 32-bit value is N_SRC or larger change no enable and no count.
- R9: A level change on a disabled line leaves the pending count unchanged. A rise or fall on an enabled line moves it up or down by one.
- R10: The request output is high exactly when the pending count is nonzero.
- R11: Writes to word offsets 0, 1 and 2 have no effect. Reads of word offsets 3, 4, 5 and of any unused offset return 0.
- R12: Address bits above bit 11 are ignored. Address 0x1004 reads the same register as 0x004.
- R13: When several lines change level in the same cycle, and a line changes in the same cycle as its own enable write, the count reflects all changes at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | N_SRC | Level interrupt lines, sampled each clock |
| bus_addr | input | AW | Byte address of the register access |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_out | output | 1 | Request to the processor |

## Verification
The embedded properties check several things on every cycle. The request output always agrees with the lowest-line finder. Any line the finder reports is active and has no active line below it. Disable-all leaves an empty enable set. Enable writes set the addressed bit, and out-of-range index writes leave the enable set untouched. Only the bench scenarios can show the numeric pending count under mixed traffic, the identification and alias reads, and the zero reads of write-only offsets. The same holds for the combined update when a line edge coincides with its own enable write. The bench compares each of these against a reference model of levels and enables.

// File: rtl/lic_pkg.sv
package lic_pkg;
   localparam int unsigned WORD_SEL_W = 10;
   localparam logic [WORD_SEL_W-1:0] OFS_IDENT   = 10'd0;
   localparam logic [WORD_SEL_W-1:0] OFS_PENDING = 10'd1;
   localparam logic [WORD_SEL_W-1:0] OFS_CURRENT = 10'd2;
   localparam logic [WORD_SEL_W-1:0] OFS_MASKALL = 10'd3;
   localparam logic [WORD_SEL_W-1:0] OFS_MASKONE = 10'd4;
   localparam logic [WORD_SEL_W-1:0] OFS_OPENONE = 10'd5;
   localparam logic [31:0] NONE_ACTIVE = 32'hFFFF_FFFF;
endpackage

// File: rtl/lic_enable_bank.sv
module lic_enable_bank #(
   parameter int unsigned N_SRC = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all,
   input  logic             clr_one,
   input  logic             set_one,
   input  logic [31:0]      sel,
   output logic [N_SRC-1:0] en_d,
   output logic [N_SRC-1:0] en_q
);
   for (genvar g = 0; g < N_SRC; g++) begin : g_bit
      logic hit;
      assign hit = (sel == 32'(g));
      always_comb begin
         en_d[g] = en_q[g];
         if (clr_all)             en_d[g] = 1'b0;
         else if (set_one && hit) en_d[g] = 1'b1;
         else if (clr_one && hit) en_d[g] = 1'b0;
      end
      always_ff @(posedge clk) begin
         if (!rst_n) en_q[g] <= 1'b0;
         else        en_q[g] <= en_d[g];
      end
   end

   // R5: a global disable leaves no enable behind
   p_clear_all_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all |=> (en_q == '0));
   // R8: an index at or above N_SRC must not touch any enable
   p_oob_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_one || clr_one) && !clr_all && (sel >= 32'(N_SRC))) |=> $stable(en_q));
endmodule

// File: rtl/lic_popcount.sv
module lic_popcount #(
   parameter int unsigned N_SRC = 64,
   parameter int unsigned CW    = 7
) (
   input  logic [N_SRC-1:0] vec,
   output logic [CW-1:0]    cnt
);
   always_comb begin
      cnt = '0;
      for (int i = 0; i < N_SRC; i++) cnt = cnt + CW'(vec[i]);
   end
endmodule

// File: rtl/lic_lowest.sv
module lic_lowest #(
   parameter int unsigned N_SRC = 64,
   parameter int unsigned IW    = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] vec,
   output logic             found,
   output logic [IW-1:0]    idx
);
   if (N_SRC == 1) begin : g_single
      assign found = vec[0];
      assign idx   = '0;
   end else begin : g_scan
      always_comb begin
         found = 1'b0;
         idx   = '0;
         for (int i = N_SRC - 1; i >= 0; i--) begin
            if (vec[i]) begin
               found = 1'b1;
               idx   = IW'(i);
            end
         end
      end
   end

   logic [N_SRC-1:0] below_mask;
   always_comb begin
      below_mask = '0;
      for (int i = 0; i < N_SRC; i++) below_mask[i] = (32'(i) < 32'(idx));
   end

   // R4: a reported line is active and nothing lower is
   p_lowest_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (vec[idx] && ((vec & below_mask) == '0)));
   p_none_means_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (vec == '0));
endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
   import lic_pkg::*;
#(
   parameter int unsigned N_SRC   = 64,
   parameter logic [31:0] ID_WORD = 32'h1C0A_0001,
   parameter int unsigned AW      = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] irq_in,
   input  logic [AW-1:0]    bus_addr,
   input  logic             bus_wr,
   input  logic [31:0]      bus_wdata,
   output logic [31:0]      bus_rdata,
   output logic             irq_out
);
   localparam int unsigned CW = $clog2(N_SRC + 1);
   localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   if (N_SRC < 1 || N_SRC > 4096) begin : g_bad_n
      $error("N_SRC must lie in 1..4096");
   end
   if (AW < 12) begin : g_bad_aw
      $error("AW must cover the 12-bit register window");
   end

   logic [WORD_SEL_W-1:0] word;
   assign word = bus_addr[11:2];

   logic do_clr_all, do_clr_one, do_set_one;
   assign do_clr_all = bus_wr && (word == OFS_MASKALL);
   assign do_clr_one = bus_wr && (word == OFS_MASKONE);
   assign do_set_one = bus_wr && (word == OFS_OPENONE);

   logic [N_SRC-1:0] en_d, en_q, lvl_q;
   lic_enable_bank #(.N_SRC(N_SRC)) u_bank (
      .clk(clk), .rst_n(rst_n), .clr_all(do_clr_all), .clr_one(do_clr_one),
      .set_one(do_set_one), .sel(bus_wdata), .en_d(en_d), .en_q(en_q));

   logic [CW-1:0] cnt_d, cnt_q;
   lic_popcount #(.N_SRC(N_SRC), .CW(CW)) u_pop (
      .vec(irq_in & en_d), .cnt(cnt_d));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lvl_q <= '0;
         cnt_q <= '0;
      end else begin
         lvl_q <= irq_in;
         cnt_q <= cnt_d;
      end
   end

   logic          cur_found;
   logic [IW-1:0] cur_idx;
   lic_lowest #(.N_SRC(N_SRC), .IW(IW)) u_low (
      .clk(clk), .rst_n(rst_n), .vec(lvl_q & en_q),
      .found(cur_found), .idx(cur_idx));

   assign irq_out = (cnt_q != '0);

   always_comb begin
      unique case (word)
         OFS_IDENT:   bus_rdata = ID_WORD;
         OFS_PENDING: bus_rdata = 32'(cnt_q);
         OFS_CURRENT: bus_rdata = cur_found ? 32'(cur_idx) : NONE_ACTIVE;
         default:     bus_rdata = '0;
      endcase
   end

   // R10: request agrees with the independent lowest-line finder
   p_req_vs_finder_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out == cur_found);
   // R6: an in-range enable write sets the addressed bit
   p_enable_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (do_set_one && (bus_wdata < 32'(N_SRC))) |=> en_q[$past(bus_wdata[IW-1:0])]);
   // R5: count reads zero after a global disable
   p_count_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      do_clr_all |=> (cnt_q == '0));
endmodule

// File: tb/lvl_irq_ctrl_test.sv
module lvl_irq_ctrl_test;
   localparam int N = 64;
   localparam time CLK_T = 10;
   localparam logic [31:0] IDV = 32'h1C0A_0001;

   logic clk = 0, rst_n = 0, bus_wr = 0, irq_out;
   logic [N-1:0] irq_in = '0;
   logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;

   lvl_irq_ctrl #(.N_SRC(N), .ID_WORD(IDV), .AW(32)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_out(irq_out));

   always #(CLK_T/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   logic [N-1:0] m_lvl = '0, m_en = '0;

   function automatic int f_count();
      int c = 0;
      for (int i = 0; i < N; i++) c += int'(m_lvl[i] & m_en[i]);
      return c;
   endfunction
   function automatic logic [31:0] f_current();
      for (int i = 0; i < N; i++) if (m_lvl[i] & m_en[i]) return 32'(i);
      return 32'hFFFF_FFFF;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // one clock with new levels and an optional write; model follows the edge
   task automatic step(logic [N-1:0] lv, bit wr, logic [31:0] a, logic [31:0] d);
      @(negedge clk);
      irq_in = lv; bus_wr = wr; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1;
      m_lvl = lv;
      if (wr) begin
         case (a[11:2])
            10'd3: m_en = '0;
            10'd4: if (d < N) m_en[d[5:0]] = 1'b0;
            10'd5: if (d < N) m_en[d[5:0]] = 1'b1;
            default: ;
         endcase
      end
   endtask

   task automatic rd(logic [31:0] a, output logic [31:0] v);
      @(negedge clk);
      bus_wr = 0; bus_addr = a;
      #1 v = bus_rdata;
   endtask

   task automatic check_state(string req);
      logic [31:0] v;
      rd(32'h4, v);  chk({req, " count"}, v, 32'(f_count()));
      rd(32'h8, v);  chk({req, " current"}, v, f_current());
      chk({req, " R10 irq_out"}, 32'(irq_out), 32'(f_count() != 0));
   endtask

   initial begin
      #(CLK_T * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      logic [N-1:0] lv;
      void'($urandom(32'd2718));
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      check_state("R1");
      // R2 identification, R12 alias above bit 11
      rd(32'h0, v);      chk("R2 ident", v, IDV);
      rd(32'h1000, v);   chk("R12 alias ident", v, IDV);
      // R6 enable a high line
      lv = '0; lv[3] = 1;
      step(lv, 1, 32'h14, 32'd3);   check_state("R6");
      rd(32'h1004, v);   chk("R12 alias count", v, 32'd1);
      // R9 disabled line rising leaves count
      lv[1] = 1;
      step(lv, 0, 0, 0);            check_state("R9 disabled rise");
      // R4 lower line becomes current when enabled
      step(lv, 1, 32'h14, 32'd1);   check_state("R4");
      // R11 writes to read-only offsets, reads of write-only offsets
      step(lv, 1, 32'h4, 32'd9);    check_state("R11 wr count");
      step(lv, 1, 32'h8, 32'd0);    check_state("R11 wr current");
      rd(32'hC, v);  chk("R11 rd offset3", v, 0);
      rd(32'h10, v); chk("R11 rd offset4", v, 0);
      rd(32'h14, v); chk("R11 rd offset5", v, 0);
      rd(32'h40, v); chk("R11 rd unused", v, 0);
      // R7 disable of enabled low line: enable 5 while low, then disable
      step(lv, 1, 32'h14, 32'd5);   check_state("R7 en low");
      step(lv, 1, 32'h10, 32'd5);   check_state("R7 dis low");
      step(lv, 1, 32'h10, 32'd3);   check_state("R7 dis high");
      // R8 out-of-range indices, including high bits set
      step(lv, 1, 32'h14, 32'd64);          check_state("R8 en 64");
      step(lv, 1, 32'h14, 32'h8000_0002);   check_state("R8 en big");
      step(lv, 1, 32'h10, 32'h0000_0041);   check_state("R8 dis 65");
      step(lv, 1, 32'h10, 32'h0001_0001);   check_state("R8 dis big");
      // R13 line rises in the same cycle as its own enable, plus other edges
      lv[63] = 1; lv[1] = 0; lv[10] = 1;
      step(lv, 1, 32'h14, 32'd63);  check_state("R13 coincident");
      // R9 enabled line falling
      lv[63] = 0;
      step(lv, 0, 0, 0);            check_state("R9 enabled fall");
      // R5 disable-all
      lv = '1;
      step(lv, 1, 32'h14, 32'd20);  check_state("R5 pre");
      step(lv, 1, 32'hC, 32'h1234); check_state("R5");
      // R3 random traffic
      for (int it = 0; it < 400; it++) begin
         logic [31:0] a, d;
         int op;
         lv = {$urandom, $urandom} & {$urandom, $urandom};
         op = $urandom_range(0, 9);
         d = ($urandom_range(0, 7) == 0) ? $urandom : 32'($urandom_range(0, 70));
         case (op)
            0, 1, 2, 3: a = 32'h14;
            4, 5, 6:    a = 32'h10;
            7:          a = 32'hC;
            default:    a = 32'($urandom_range(0, 2)) << 2;
         endcase
         if ($urandom_range(0, 1) == 1) a = a | 32'h0000_5000;
         step(lv, op != 8, a, d);
         check_state("R3 random");
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule